// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Read-Then-Clear Status Flags

This block is a single timer channel. A 16-bit up-counter, started and stopped by a run bit, is shared by two general registers and by a bank of eight compare-only registers. Each general register can be set to either of two modes. In capture mode it takes a snapshot of the counter on a rising edge of its capture pin. In compare mode it raises a one-cycle match pulse when the counter reaches its value. Each compare-only register also raises a one-cycle pulse on a match.

Every event is recorded in a sticky status flag. The two general-register flags are in a first status register. The eight compare-only flags and a counter-wrap flag are in a second status register. Software clears a flag with a two-step handshake: it reads the flag while the flag is 1, then writes 0 to that bit. Writing 1 never sets a flag. Any write to a status register cancels a pending read, so a clear cannot act on an old read.

Software reaches the block through a flat register bus: address, read strobe, write strobe, write data, and combinational read data.

Top module: `ccmp_timer`

## Requirements
- R1: Register map on the 4-bit address: 0 = counter, 1 = control, 2 = general register A, 3 = general register B, 4 = first status register, 5 = second status register, 8+k = compare register k (k = 0..7). Control bit 0 puts A in capture mode (0 = compare mode), bit 1 does the same for B, and bit 2 runs the counter. Written values read back, control reads back only its 3 bits, and unmapped bits read as 0.
- R2: After reset, the counter, the control register, all general and compare registers and all flags are 0, and no match output is active.
- R3: While the run bit is 1, the counter increments once per clock. A write to the counter takes priority over the increment. An increment from 0xFFFF goes to 0x0000 and sets the wrap flag in bit 8 of the second status register.
- R4: In capture mode, a rising edge on the register's capture pin (cap_i bit 0 for A, bit 1 for B) is passed through a two-stage synchroniser. On the third clock edge after the pin rises, the register loads the counter value and its flag sets (first status register bit 0 for A, bit 1 for B).
- R5: A falling edge on a capture pin captures nothing. In compare mode, the capture pin changes neither the register nor its flag.
- R6: In compare mode, when the counter becomes equal to the general register, that register's flag sets and its gr_match_o bit pulses high for one cycle.
- R7: When the counter becomes equal to compare register k, bit k of the second status register sets and cmp_match_o bit k pulses high for one cycle.
- R8: A match is reported once, when equality begins. While the counter and the register stay equal, no further pulse occurs and a flag that has been cleared stays 0.
- R9: A flag clears only when it was read as 1 and 0 is then written to its bit. A write of 0 with no such earlier read leaves the flag set.
- R10: Writing 1 to a flag bit has no effect. A flag that is 0 stays 0, and a flag that is 1 stays 1.
- R11: Any write to a status register cancels the read-as-1 record for every flag in that register. A 0 written after an intervening write does not clear the flag.
- R12: If a set event and a valid clearing write hit the same flag in the same cycle, the flag ends at 1.
- R13: Bits 15..2 of the first status register and bits 15..9 of the second always read as 0, even after writes of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 4 | Register address |
| rd_i | input | 1 | Read strobe; arms status flags when the address is a status register |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the addressed register (combinational) |
| cap_i | input | 2 | Asynchronous capture pins for general registers A and B |
| gr_match_o | output | 2 | One-cycle compare-match pulses for general registers A and B |
| cmp_match_o | output | 8 | One-cycle match pulses for compare registers 0..7 |

## Verification
A flag bank that lost its read record, or kept one it should have dropped, changes the result of the very next status read after a write of 0. That is why the bench runs the read, write and read steps back to back, with no idle cycles between them. A match detector that forgot it had already seen equality would pulse again within one cycle, and the pulse counters would catch it. A synchroniser with the wrong depth would capture on the wrong edge, and with the counter stopped this shows up as a flag or captured value in the readback a few cycles later. A wrong priority between set and clear shows up in a single-cycle test: a capture edge is placed on the same edge as the clearing write, and the status read that follows reveals which one won.

// File: rtl/ccmp_pkg.sv
package ccmp_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NUM_GR = 2;
  localparam int unsigned NUM_CMP = 8;
  localparam int unsigned CTRL_W = NUM_GR + 1;
  localparam int unsigned CTRL_RUN = NUM_GR;

  localparam logic [ADDR_W-1:0] A_CNT  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd1;
  localparam logic [ADDR_W-1:0] A_GR0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_STS1 = 4'd4;
  localparam logic [ADDR_W-1:0] A_STS2 = 4'd5;
  localparam int unsigned CMP_BASE = 8;
endpackage

// File: rtl/ccmp_counter.sv
module ccmp_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld_i | run_i;
    cnt_d  = ld_i ? ld_val_i : (cnt_q + 1'b1);
    wrap_o = run_i & ~ld_i & (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_wrap_to_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));
  p_hold_when_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_i) |=> $stable(cnt_o));
endmodule

// File: rtl/ccmp_edge_sync.sv
module ccmp_edge_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [2:0] sh_q, sh_d;

    always_comb sh_d = {sh_q[1:0], pin_i[g]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= sh_d;
    end

    assign rise_o[g] = sh_q[1] & ~sh_q[2];

    p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
    p_rise_needs_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |-> $past(pin_i[g], 2));
  end
endmodule

// File: rtl/ccmp_match.sv
module ccmp_match #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0]        cnt_i,
  input  logic [N-1:0][W-1:0] ref_i,
  input  logic [N-1:0]        en_i,
  output logic [N-1:0]        evt_o
);
  logic [N-1:0] eq, eq_q;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g]    = (cnt_i == ref_i[g]);
    assign evt_o[g] = eq[g] & ~eq_q[g] & en_i[g];

    p_evt_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o[g] |=> !evt_o[g]);
  end

  // Reset to "already equal" so reset values that coincide do not report a match.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= '1;
    else         eq_q <= eq;
  end
endmodule

// File: rtl/ccmp_flag_bank.sv
module ccmp_flag_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] armed_q, armed_d;
  logic [N-1:0] clr;

  always_comb begin
    clr     = {N{wr_i}} & armed_q & ~wdata_i;
    flag_d  = set_i | (flag_q & ~clr);
    if (wr_i)      armed_d = '0;
    else if (rd_i) armed_d = flag_q;
    else           armed_d = armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    p_no_self_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o[g] && !set_i[g]) |=> !flag_o[g]);
    p_clear_needs_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[g] && !(wr_i && armed_q[g] && !wdata_i[g])) |=> flag_o[g]);
  end
endmodule

// File: rtl/ccmp_timer.sv
module ccmp_timer
  import ccmp_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned NC = NUM_CMP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [NUM_GR-1:0] cap_i,
  output logic [NUM_GR-1:0] gr_match_o,
  output logic [NC-1:0]     cmp_match_o
);
  localparam int unsigned S2_W = NC + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic [CTRL_W-1:0]          ctrl_q, ctrl_d;
  logic [NUM_GR-1:0][W-1:0]   gr_q, gr_d;
  logic [NC-1:0][W-1:0]       cmp_q, cmp_d;
  logic [NUM_GR-1:0]          gr_match_q, cmp_mode;
  logic [NC-1:0]              cmp_match_q;
  logic [W-1:0]               cnt;
  logic                       wrap, cnt_ld;
  logic [NUM_GR-1:0]          rise, gr_evt, sts1_set, sts1;
  logic [NC-1:0]              cmp_evt;
  logic [S2_W-1:0]            sts2_set, sts2;
  logic                       sel_s1, sel_s2;

  assign cnt_ld   = wr_i && (addr_i == A_CNT);
  assign sel_s1   = (addr_i == A_STS1);
  assign sel_s2   = (addr_i == A_STS2);
  assign cmp_mode = ~ctrl_q[NUM_GR-1:0];

  ccmp_counter #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(ctrl_q[CTRL_RUN]),
    .ld_i(cnt_ld), .ld_val_i(wdata_i), .cnt_o(cnt), .wrap_o(wrap)
  );

  ccmp_edge_sync #(.N(NUM_GR)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .pin_i(cap_i), .rise_o(rise)
  );

  ccmp_match #(.W(W), .N(NUM_GR)) u_gr_match (
    .clk_i(clk_i), .rst_ni(rst_n), .cnt_i(cnt), .ref_i(gr_q),
    .en_i(cmp_mode), .evt_o(gr_evt)
  );

  ccmp_match #(.W(W), .N(NC)) u_cmp_match (
    .clk_i(clk_i), .rst_ni(rst_n), .cnt_i(cnt), .ref_i(cmp_q),
    .en_i({NC{1'b1}}), .evt_o(cmp_evt)
  );

  assign sts1_set = (ctrl_q[NUM_GR-1:0] & rise) | gr_evt;
  assign sts2_set = {wrap, cmp_evt};

  ccmp_flag_bank #(.N(NUM_GR)) u_sts1 (
    .clk_i(clk_i), .rst_ni(rst_n), .set_i(sts1_set),
    .rd_i(rd_i && sel_s1), .wr_i(wr_i && sel_s1),
    .wdata_i(wdata_i[NUM_GR-1:0]), .flag_o(sts1)
  );

  ccmp_flag_bank #(.N(S2_W)) u_sts2 (
    .clk_i(clk_i), .rst_ni(rst_n), .set_i(sts2_set),
    .rd_i(rd_i && sel_s2), .wr_i(wr_i && sel_s2),
    .wdata_i(wdata_i[S2_W-1:0]), .flag_o(sts2)
  );

  // Register file next state.
  always_comb begin
    ctrl_d = ctrl_q;
    gr_d   = gr_q;
    cmp_d  = cmp_q;
    if (wr_i && (addr_i == A_CTRL)) ctrl_d = wdata_i[CTRL_W-1:0];
    for (int g = 0; g < NUM_GR; g++) begin
      if (wr_i && (int'(addr_i) == int'(A_GR0) + g)) gr_d[g] = wdata_i;
      if (ctrl_q[g] && rise[g])                      gr_d[g] = cnt;
    end
    for (int k = 0; k < NC; k++) begin
      if (wr_i && (int'(addr_i) == CMP_BASE + k)) cmp_d[k] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      gr_q        <= '0;
      cmp_q       <= '0;
      gr_match_q  <= '0;
      cmp_match_q <= '0;
    end else begin
      ctrl_q      <= ctrl_d;
      gr_q        <= gr_d;
      cmp_q       <= cmp_d;
      gr_match_q  <= gr_evt;
      cmp_match_q <= cmp_evt;
    end
  end

  assign gr_match_o  = gr_match_q;
  assign cmp_match_o = cmp_match_q;

  // Read mux.
  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CNT)  rdata_o = cnt;
    if (addr_i == A_CTRL) rdata_o[CTRL_W-1:0] = ctrl_q;
    if (sel_s1)           rdata_o[NUM_GR-1:0] = sts1;
    if (sel_s2)           rdata_o[S2_W-1:0] = sts2;
    for (int g = 0; g < NUM_GR; g++)
      if (int'(addr_i) == int'(A_GR0) + g) rdata_o = gr_q[g];
    for (int k = 0; k < NC; k++)
      if (int'(addr_i) == CMP_BASE + k) rdata_o = cmp_q[k];
  end

  p_ovf_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap |=> sts2[NC]);

  for (genvar g = 0; g < NUM_GR; g++) begin : g_gr_chk
    p_capture_loads_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
      (ctrl_q[g] && rise[g]) |=> (gr_q[g] == $past(cnt)));
    p_match_once_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
      gr_match_o[g] |=> !gr_match_o[g]);
    p_match_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
      gr_match_o[g] |-> sts1[g]);
  end
endmodule

// File: tb/ccmp_timer_tb_top.sv
module ccmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  cap = '0;
  logic [1:0]  gr_match;
  logic [7:0]  cmp_match;

  int n_chk = 0, n_fail = 0;
  int grm0 = 0, grm1 = 0, cmp_tot = 0, cmp7 = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ccmp_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap),
    .gr_match_o(gr_match), .cmp_match_o(cmp_match)
  );

  // Monitor: pops the expected item for each read strobe.
  always @(negedge clk) begin
    if (rd) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", t, addr, rdata, e);
      end
    end
    if (rst_n) begin
      grm0 += int'(gr_match[0]);
      grm1 += int'(gr_match[1]);
      cmp_tot += $countones(cmp_match);
      cmp7 += int'(cmp_match[7]);
    end
  end

  task automatic chk(input string t, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, expv);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1; addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1; addr = a; rd = 1'b1;
    @(posedge clk); #1; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3); #1; rst_n = 1'b1;
    idle(4);
    // R2 reset state
    bus_rd(4'd0, 16'h0000, "R2 counter");
    bus_rd(4'd1, 16'h0000, "R2 control");
    bus_rd(4'd2, 16'h0000, "R2 gra");
    bus_rd(4'd11, 16'h0000, "R2 cmp3");
    bus_rd(4'd4, 16'h0000, "R2 sts1");
    bus_rd(4'd5, 16'h0000, "R2 sts2");
    chk("R2 match outputs idle", grm0 + grm1 + cmp_tot, 0);

    // R1 map and readback
    bus_wr(4'd2, 16'h1234);
    bus_wr(4'd3, 16'hABCD);
    bus_wr(4'd11, 16'h0F0F);
    bus_wr(4'd1, 16'hFFFB);
    bus_rd(4'd2, 16'h1234, "R1 gra");
    bus_rd(4'd3, 16'hABCD, "R1 grb");
    bus_rd(4'd11, 16'h0F0F, "R1 cmp3");
    bus_rd(4'd1, 16'h0003, "R1 control width");

    // R4 capture on A with stopped counter
    bus_wr(4'd0, 16'h0555);
    @(posedge clk); #1; cap[0] = 1'b1;
    idle(5);
    bus_rd(4'd2, 16'h0555, "R4 gra captured");
    bus_rd(4'd3, 16'hABCD, "R4 grb untouched");
    bus_rd(4'd4, 16'h0001, "R4 flag A");
    // R5 falling edge captures nothing
    bus_wr(4'd0, 16'h0666);
    @(posedge clk); #1; cap[0] = 1'b0;
    idle(5);
    bus_rd(4'd2, 16'h0555, "R5 falling edge gra");

    // R11 / R9 / R10 clear protocol (A armed by the R4 read)
    bus_wr(4'd4, 16'h0001);
    bus_wr(4'd4, 16'h0000);
    bus_rd(4'd4, 16'h0001, "R11 stale arm");
    bus_wr(4'd4, 16'h0000);
    bus_rd(4'd4, 16'h0000, "R9 read then clear");
    bus_wr(4'd4, 16'hFFFF);
    bus_rd(4'd4, 16'h0000, "R10 R13 write ones");
    @(posedge clk); #1; cap[1] = 1'b1;
    idle(5);
    bus_wr(4'd4, 16'h0000);
    bus_rd(4'd4, 16'h0002, "R9 clear without read");
    bus_rd(4'd3, 16'h0666, "R4 grb captured");

    // R12 set and clear in the same cycle (B armed by next read)
    @(posedge clk); #1; cap[1] = 1'b0;
    idle(5);
    bus_rd(4'd4, 16'h0002, "R12 pre");
    @(posedge clk); #1; cap[1] = 1'b1;
    @(posedge clk);
    @(posedge clk); #1; addr = 4'd4; wdata = 16'h0000; wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0;
    bus_rd(4'd4, 16'h0002, "R12 set wins");

    // R6 / R8 compare on general registers
    bus_wr(4'd1, 16'h0000);
    bus_rd(4'd4, 16'h0002, "R8 no match on mode change");
    bus_wr(4'd4, 16'h0000);
    bus_wr(4'd2, 16'h0666);
    idle(10);
    chk("R8 single pulse A", grm0, 1);
    bus_rd(4'd4, 16'h0001, "R6 flag A on equal");
    bus_wr(4'd4, 16'h0000);
    bus_rd(4'd4, 16'h0000, "R8 stays clear while equal");
    bus_wr(4'd2, 16'h0680);
    bus_wr(4'd1, 16'h0004);
    idle(60);
    bus_wr(4'd1, 16'h0000);
    bus_rd(4'd4, 16'h0001, "R6 running match");
    chk("R6 pulse count A", grm0, 2);
    chk("R6 pulse count B", grm1, 0);
    bus_wr(4'd4, 16'h0000);
    @(posedge clk); #1; cap[0] = 1'b1;
    idle(5);
    @(posedge clk); #1; cap[0] = 1'b0;
    idle(5);
    bus_rd(4'd2, 16'h0680, "R5 compare ignores pin");
    bus_rd(4'd4, 16'h0000, "R5 no flag in compare");

    // R7 compare registers
    bus_wr(4'd0, 16'h1FF0);
    for (int k = 0; k < 7; k++) bus_wr(4'(8 + k), 16'(16'h2000 + 2 * k));
    bus_wr(4'd15, 16'h3000);
    bus_wr(4'd1, 16'h0004);
    idle(40);
    bus_wr(4'd1, 16'h0000);
    bus_rd(4'd5, 16'h007F, "R7 compare flags");
    chk("R7 pulse total", cmp_tot, 7);
    chk("R7 unreached register", cmp7, 0);

    // R3 counter and overflow
    bus_wr(4'd1, 16'h0004);
    bus_wr(4'd0, 16'hFFF0);
    bus_rd(4'd0, 16'hFFF1, "R3 increment");
    idle(30);
    bus_wr(4'd1, 16'h0000);
    bus_rd(4'd5, 16'h017F, "R3 overflow flag");
    bus_wr(4'd5, 16'h00FF);
    bus_rd(4'd5, 16'h007F, "R9 R10 clear overflow only");
    bus_wr(4'd5, 16'hFFFF);
    bus_rd(4'd5, 16'h007F, "R13 reserved bits");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule